// File: doc/BRIEF.md
# Two-Lane Shift-Mask-Add Interpolator

This block is an arithmetic helper that sits behind a simple register port. It holds two lanes. Each lane has a 32-bit accumulator, its own base and a control word, and a third base is shared by both lanes. Each lane picks a source, which is its own accumulator or the accumulator of the other lane. It shifts the source right, keeps a chosen window of bits and may sign-extend what is left. A base is then added to form the lane result. A combined result adds the shared base to the windowed values of both lanes.

Software reads the lane results and the combined result in one of two ways. A peek read only returns the value. A pop read returns the same value and, at the same clock edge, writes the lane results back into the accumulators, so repeated pops step through a sequence such as addresses or texture coordinates. A blend mode turns lane 1 into a linear interpolator between two bases, using an 8-bit fraction. Overflow flags report bits that the window threw away.

Top module: `interp2`

## Requirements
- R1: After reset every accumulator, base and control register reads back as zero, and so do the overflow flags.
- R2: Word addresses are accumulator 0/1 at 0/1, bases 0/1/2 at 2/3/4, control 0/1 at 5/6, peek lane0/lane1/combined at 8/9/10 and pop lane0/lane1/combined at 12/13/14. The control word fields are shift [4:0], window low bit [9:5], window high bit [14:10], sign-extend [15], take peer input [16], take peer result [17], add raw source [18], bus upper-bit force [20:19] and blend [21]. Blend exists only in control 0. Reads return data in the cycle that rd_en is high.
- R3: A lane shifts its source right logically by 0 to 31 and keeps bits low..high inclusive. When high is below low the window is empty and the windowed value is zero.
- R4: With sign-extend set, the windowed value is extended from the window high bit to 32 bits before it is added and before it is summed into the combined result.
- R5: With take-peer-input set, a lane feeds the other lane's accumulator into its shift stage, and this choice still holds when add-raw is set.
- R6: With add-raw set, the lane result is base plus the unshifted source. The combined result still uses the windowed value.
- R7: Outside blend mode, the combined result is base 2 plus the extended windowed values of both lanes, and lane n's result is base n plus its addend.
- R8: A peek changes no state. A pop returns the same value as a peek and, at that edge, loads each accumulator with its own lane result, or with the other lane's result when take-peer-result is set.
- R9: The force field is ORed into bits 29:28 of lane reads only. It does not change the combined read or the value written back by a pop.
- R10: Control 0 reads back the lane 0 flag at bit 23, the lane 1 flag at bit 24 and their OR at bit 25. A lane's flag is set when its shifted value has a one outside the window. The flags are read-only.
- R11: In blend mode, lane 1's result is floor(B0 + (B1 − B0)·f/256), where f is the low 8 bits of lane 1's windowed value. The bases are taken as signed or unsigned according to lane 1's sign-extend bit.
- R12: In blend mode, lane 0's result is f zero-extended, and the combined result is base 2 plus lane 0's extended windowed value only.
- R13: A register write to an accumulator in the same cycle as a pop takes priority for that accumulator. The other accumulator still takes its pop value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; a read at a pop address also updates the accumulators |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data, combinational, zero when rd_en is low |

## Verification
A pop write-back and a register write to an accumulator can land on the same clock edge, because the read and write ports are independent. The bench drives a pop read together with a write to accumulator 1 in one cycle. It then reads both accumulators: the written one must hold the written data, and the other must hold the result of its lane. The same collision is guarded by a clocked property that states write priority over the pop path.

// File: rtl/interp_pkg.sv
package interp_pkg;

  localparam int REG_AW = 4;
  localparam int CTL_W  = 22;

  // Control word layout (LSB first): shift, window low, window high, sign,
  // peer input, peer result, raw add, bus force, blend.
  typedef struct packed {
    logic       mix;
    logic [1:0] frc;
    logic       raw;
    logic       xres;
    logic       xin;
    logic       sgn;
    logic [4:0] hi;
    logic [4:0] lo;
    logic [4:0] sh;
  } ictrl_t;

  typedef enum logic [REG_AW-1:0] {
    A_ACC0  = 4'd0,
    A_ACC1  = 4'd1,
    A_BASE0 = 4'd2,
    A_BASE1 = 4'd3,
    A_BASE2 = 4'd4,
    A_CTL0  = 4'd5,
    A_CTL1  = 4'd6,
    A_PK0   = 4'd8,
    A_PK1   = 4'd9,
    A_PKF   = 4'd10,
    A_PP0   = 4'd12,
    A_PP1   = 4'd13,
    A_PPF   = 4'd14
  } iaddr_e;

endpackage

// File: rtl/interp_lane.sv
module interp_lane
  import interp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] own_acc,
  input  logic [DW-1:0] peer_acc,
  input  ictrl_t        ctl,
  output logic [DW-1:0] src,
  output logic [DW-1:0] sm,
  output logic [DW-1:0] ext,
  output logic          ovf
);

  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  // Window of kept bits, empty when the high bound is below the low bound.
  function automatic logic [DW-1:0] window_of(input logic [4:0] lo, input logic [4:0] hi);
    if (hi < lo) return '0;
    return (ONES << lo) & (ONES >> (DW - 1 - int'(hi)));
  endfunction

  // Extend from bit hi upward; bits above hi are already clear.
  function automatic logic [DW-1:0] extend_from(input logic [DW-1:0] v, input logic [4:0] hi);
    if (v[hi]) return v | (ONES << hi);
    return v;
  endfunction

  logic [DW-1:0] shifted;
  logic [DW-1:0] win;

  always_comb begin
    src     = ctl.xin ? peer_acc : own_acc;
    shifted = src >> ctl.sh;
    win     = window_of(ctl.lo, ctl.hi);
    sm      = shifted & win;
    ext     = ctl.sgn ? extend_from(sm, ctl.hi) : sm;
    ovf     = |(shifted & ~win);
  end

  // R3: an inverted window yields nothing
  assert_empty_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.hi < ctl.lo) |-> (sm == '0));

  // R10: a raised flag means the window dropped a one
  assert_flag_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (shifted != sm));

  // R4: extension never disturbs the windowed bits
  assert_ext_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext & win) == sm));

endmodule

// File: rtl/interp_blend.sv
module interp_blend #(
  parameter int DW = 32,
  parameter int FW = 8
) (
  input  logic [DW-1:0] b0,
  input  logic [DW-1:0] b1,
  input  logic [FW-1:0] frac,
  input  logic          sgn,
  output logic [DW-1:0] mixv
);

  // b0 + floor((b1 - b0) * frac / 2^FW), bases signed or unsigned.
  function automatic logic [DW-1:0] lerp(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                         input logic [FW-1:0] f, input logic s);
    logic signed [DW:0]      d;
    logic signed [DW+FW+1:0] p;
    logic signed [DW+FW+1:0] q;
    d = $signed({s & b[DW-1], b}) - $signed({s & a[DW-1], a});
    p = d * $signed({1'b0, f});
    q = p >>> FW;
    return a + q[DW-1:0];
  endfunction

  assign mixv = lerp(b0, b1, frac, sgn);

endmodule

// File: rtl/interp2.sv
module interp2
  import interp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int FORCE_LSB = DATA_W - 4;
  localparam int FLAG_LSB  = CTL_W + 1;

  logic [DATA_W-1:0] acc_q  [2];
  logic [DATA_W-1:0] base_q [3];
  ictrl_t            ctl_q  [2];

  logic [DATA_W-1:0] src_w [2];
  logic [DATA_W-1:0] sm_w  [2];
  logic [DATA_W-1:0] ext_w [2];
  logic              ovf_w [2];

  for (genvar l = 0; l < 2; l++) begin : g_lane
    interp_lane #(.DW(DATA_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .own_acc  (acc_q[l]),
      .peer_acc (acc_q[1-l]),
      .ctl      (ctl_q[l]),
      .src      (src_w[l]),
      .sm       (sm_w[l]),
      .ext      (ext_w[l]),
      .ovf      (ovf_w[l])
    );
  end

  logic [DATA_W-1:0] mix_w;

  interp_blend #(.DW(DATA_W), .FW(FRAC_W)) u_mix (
    .b0   (base_q[0]),
    .b1   (base_q[1]),
    .frac (sm_w[1][FRAC_W-1:0]),
    .sgn  (ctl_q[1].sgn),
    .mixv (mix_w)
  );

  function automatic logic [DATA_W-1:0] bus_view(input logic [DATA_W-1:0] v, input logic [1:0] f);
    return v | ({{(DATA_W-2){1'b0}}, f} << FORCE_LSB);
  endfunction

  // Lane and combined results on the internal datapath.
  logic              mix_on;
  logic [DATA_W-1:0] res0, res1, full, bus0, bus1;

  always_comb begin
    mix_on = ctl_q[0].mix;
    res0   = mix_on ? {{(DATA_W-FRAC_W){1'b0}}, sm_w[1][FRAC_W-1:0]}
                    : base_q[0] + (ctl_q[0].raw ? src_w[0] : ext_w[0]);
    res1   = mix_on ? mix_w
                    : base_q[1] + (ctl_q[1].raw ? src_w[1] : ext_w[1]);
    full   = base_q[2] + ext_w[0] + (mix_on ? '0 : ext_w[1]);
    bus0   = bus_view(res0, ctl_q[0].frc);
    bus1   = bus_view(res1, ctl_q[1].frc);
  end

  logic pop, wr_acc0, wr_acc1, peek;
  assign pop     = rd_en && (rd_addr == A_PP0 || rd_addr == A_PP1 || rd_addr == A_PPF);
  assign peek    = rd_en && (rd_addr == A_PK0 || rd_addr == A_PK1 || rd_addr == A_PKF);
  assign wr_acc0 = wr_en && (wr_addr == A_ACC0);
  assign wr_acc1 = wr_en && (wr_addr == A_ACC1);

  // Configuration registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q[0] <= '0;
      base_q[1] <= '0;
      base_q[2] <= '0;
      ctl_q[0]  <= '0;
      ctl_q[1]  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_BASE0: base_q[0] <= wr_data;
        A_BASE1: base_q[1] <= wr_data;
        A_BASE2: base_q[2] <= wr_data;
        A_CTL0:  ctl_q[0]  <= ictrl_t'(wr_data[CTL_W-1:0]);
        A_CTL1: begin
          ctl_q[1]     <= ictrl_t'(wr_data[CTL_W-1:0]);
          ctl_q[1].mix <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // Accumulators: a direct write beats a pop write-back.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q[0] <= '0;
      acc_q[1] <= '0;
    end else begin
      if (wr_acc0)  acc_q[0] <= wr_data;
      else if (pop) acc_q[0] <= ctl_q[0].xres ? res1 : res0;
      if (wr_acc1)  acc_q[1] <= wr_data;
      else if (pop) acc_q[1] <= ctl_q[1].xres ? res0 : res1;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (rd_addr)
        A_ACC0:          rd_data = acc_q[0];
        A_ACC1:          rd_data = acc_q[1];
        A_BASE0:         rd_data = base_q[0];
        A_BASE1:         rd_data = base_q[1];
        A_BASE2:         rd_data = base_q[2];
        A_CTL0:          rd_data = {{(DATA_W-FLAG_LSB-3){1'b0}}, ovf_w[0] | ovf_w[1],
                                    ovf_w[1], ovf_w[0], 1'b0, ctl_q[0]};
        A_CTL1:          rd_data = {{(DATA_W-CTL_W){1'b0}}, ctl_q[1]};
        A_PK0, A_PP0:    rd_data = bus0;
        A_PK1, A_PP1:    rd_data = bus1;
        A_PKF, A_PPF:    rd_data = full;
        default:         rd_data = '0;
      endcase
    end
  end

  // R8: a peek leaves both accumulators alone
  assert_peek_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (peek && !wr_en) |=> ($stable(acc_q[0]) && $stable(acc_q[1])));

  // R8: pop loads lane 0's own result when not crossed
  assert_pop_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !wr_acc0 && !ctl_q[0].xres) |=> (acc_q[0] == $past(res0)));

  // R13: a direct write wins over a coincident pop
  assert_write_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc1 && pop) |=> (acc_q[1] == $past(wr_data)));

  // R11: unsigned blend stays between the two bases
  assert_blend_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_on && !ctl_q[1].sgn) |->
      ((res1 >= base_q[0] && res1 <= base_q[1]) || (res1 >= base_q[1] && res1 <= base_q[0])));

  // R9: the force field never reaches the combined read
  assert_force_bus_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_PKF) |-> (rd_data == full));

endmodule

// File: tb/tb_interp2.sv
module tb_interp2;
  import interp_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  interp2 dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [31:0] mkc(int sh, int lo, int hi, int sg, int xi, int xr,
                                      int rw, int fr, int mx);
    logic [31:0] c;
    c = 32'(sh & 31) | (32'(lo & 31) << 5) | (32'(hi & 31) << 10) | (32'(sg & 1) << 15)
      | (32'(xi & 1) << 16) | (32'(xr & 1) << 17) | (32'(rw & 1) << 18)
      | (32'(fr & 3) << 19) | (32'(mx & 1) << 21);
    return c;
  endfunction

  typedef struct packed {
    logic [31:0] a0, a1, b0, b1, b2, c0, c1;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 32'h0000_00F0, 32'h0000_0100, 32'h0000_0200, 32'h0000_1000,
      mkc(4,0,7,0,0,0,0,0,0), mkc(0,4,7,0,0,0,0,0,0)},
    '{32'hFFFF_FF80, 32'h8000_0001, 32'h0000_0010, 32'h0000_0020, 32'h0000_0003,
      mkc(0,0,7,1,0,0,0,0,0), mkc(28,0,3,1,0,0,0,0,0)},
    '{32'h0000_0011, 32'h0000_0A00, 32'h0000_0001, 32'h0000_0002, 32'h0000_0005,
      mkc(8,0,3,0,1,1,0,0,0), mkc(0,0,7,0,0,0,0,0,0)},
    '{32'h0ABC_0010, 32'h0000_0F0F, 32'h2000_0000, 32'h0100_0000, 32'h0000_0000,
      mkc(4,0,3,0,1,0,1,3,0), mkc(4,0,3,0,0,1,0,2,0)},
    '{32'h0000_0003, 32'h0000_0040, 32'd100,       32'd300,       32'h0000_0007,
      mkc(0,0,1,0,0,0,0,0,1), mkc(0,0,7,0,0,0,0,0,0)},
    '{32'h0000_00FF, 32'h0000_0080, 32'hFFFF_FF00, 32'h0000_0100, 32'h0000_0000,
      mkc(0,0,7,1,0,0,0,1,1), mkc(0,0,7,1,0,0,0,0,0)},
    '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0005, 32'h0000_0000, 32'h0000_0009,
      mkc(31,0,0,0,0,0,0,0,0), mkc(0,0,31,0,0,0,0,0,0)},
    '{32'h0000_0001, 32'h0000_00C0, 32'hF000_0000, 32'h1000_0000, 32'h0000_0000,
      mkc(0,0,3,0,0,0,0,0,1), mkc(0,0,7,0,0,0,0,0,0)}
  };

  typedef struct {
    logic [31:0] l0, l1, full;
    bit          f0, f1;
  } exp_t;

  // Bench view of one lane's shift stage, bit by bit.
  task automatic stage(input logic [31:0] a, input logic [31:0] c,
                       output logic [31:0] smv, output logic [31:0] extv, output bit ov);
    int sh, lo, hi;
    logic [31:0] s;
    sh = int'(c[4:0]); lo = int'(c[9:5]); hi = int'(c[14:10]);
    s = a >> sh;
    smv = '0; ov = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (i >= lo && i <= hi) smv[i] = s[i];
      else if (s[i]) ov = 1'b1;
    end
    extv = smv;
    if (c[15] && hi >= lo && smv[hi])
      for (int i = 0; i < 32; i++) if (i > hi) extv[i] = 1'b1;
  endtask

  task automatic model(input vec_t v, output exp_t e);
    logic [31:0] src0, src1, sm0, sm1, x0, x1;
    bit o0, o1;
    longint w0, w1, t;
    src0 = v.c0[16] ? v.a1 : v.a0;
    src1 = v.c1[16] ? v.a0 : v.a1;
    stage(src0, v.c0, sm0, x0, o0);
    stage(src1, v.c1, sm1, x1, o1);
    e.f0 = o0; e.f1 = o1;
    if (v.c0[21]) begin
      w0 = v.c1[15] ? longint'($signed(v.b0)) : longint'({32'b0, v.b0});
      w1 = v.c1[15] ? longint'($signed(v.b1)) : longint'({32'b0, v.b1});
      t  = ((w1 - w0) * longint'({56'b0, sm1[7:0]})) >>> 8;
      e.l1   = 32'(w0 + t);
      e.l0   = {24'b0, sm1[7:0]};
      e.full = v.b2 + x0;
    end else begin
      e.l0   = v.b0 + (v.c0[18] ? src0 : x0);
      e.l1   = v.b1 + (v.c1[18] ? src1 : x1);
      e.full = v.b2 + x0 + x1;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic load(input vec_t v);
    wr(A_ACC0, v.a0); wr(A_ACC1, v.a1);
    wr(A_BASE0, v.b0); wr(A_BASE1, v.b1); wr(A_BASE2, v.b2);
    wr(A_CTL0, v.c0); wr(A_CTL1, v.c1);
  endtask

  function automatic logic [31:0] frc(input logic [31:0] v, input logic [31:0] c);
    return v | ({30'b0, c[20:19]} << 28);
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    exp_t e;
    vec_t v;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state of every storage register and of the flags
    for (int a = 0; a < 7; a++) begin
      rd(4'(a), d);
      check($sformatf("R1 reset reg %0d", a), d, 32'h0);
    end
    rd(A_PKF, d);
    check("R1 combined after reset", d, 32'h0);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      load(v);
      model(v, e);
      rd(A_PK0, d);
      check($sformatf("R7/R9/R12 v%0d peek lane0", i), d, frc(e.l0, v.c0));
      rd(A_PK1, d);
      check($sformatf("R7/R9/R11 v%0d peek lane1", i), d, frc(e.l1, v.c1));
      rd(A_PKF, d);
      check($sformatf("R7/R9/R12 v%0d peek combined", i), d, e.full);
      rd(A_CTL0, d);
      check($sformatf("R10 v%0d control0 flags", i), d,
            (v.c0 & 32'h003F_FFFF) | (32'(e.f0) << 23) | (32'(e.f1) << 24) | (32'(e.f0 | e.f1) << 25));
      rd(4'(12 + (i % 3)), d);
      check($sformatf("R8 v%0d pop value", i), d,
            (i % 3 == 0) ? frc(e.l0, v.c0) : (i % 3 == 1) ? frc(e.l1, v.c1) : e.full);
      rd(A_ACC0, d);
      check($sformatf("R8/R9 v%0d acc0 after pop", i), d, v.c0[17] ? e.l1 : e.l0);
      rd(A_ACC1, d);
      check($sformatf("R8/R9 v%0d acc1 after pop", i), d, v.c1[17] ? e.l0 : e.l1);
    end

    // R3: empty window (high below low) with sign set; R10 flag raised
    load('{32'hFFFF_FFFF, 32'h0, 32'd5, 32'd0, 32'd0, mkc(0,9,3,1,0,0,0,0,0), 32'h0});
    rd(A_PK0, d);
    check("R3 empty window lane0", d, 32'd5);
    rd(A_CTL0, d);
    check("R10 empty window flags", d, 32'h0280_8D20);

    // R3: shift of 31 with a one-bit window
    load('{32'h8000_0000, 32'h0, 32'd5, 32'd0, 32'd0, mkc(31,0,0,0,0,0,0,0,0), 32'h0});
    rd(A_PK0, d);
    check("R3 shift 31", d, 32'd6);

    // R3: shift of 0 with a full window
    load('{32'hDEAD_BEEF, 32'h0, 32'd0, 32'd0, 32'd0, mkc(0,0,31,0,0,0,0,0,0), 32'h0});
    rd(A_PK0, d);
    check("R3 shift 0", d, 32'hDEAD_BEEF);

    // R8: a peek leaves the accumulator unchanged
    rd(A_PK0, d);
    rd(A_ACC0, d);
    check("R8 peek keeps acc0", d, 32'hDEAD_BEEF);

    // R13: pop and accumulator write in the same cycle
    load('{32'h10, 32'h20, 32'h1, 32'h2, 32'h0,
           mkc(0,0,31,0,0,0,0,0,0), mkc(0,0,31,0,0,0,0,0,0)});
    @(negedge clk);
    rd_en = 1'b1; rd_addr = A_PP0;
    wr_en = 1'b1; wr_addr = A_ACC1; wr_data = 32'h0000_ABCD;
    @(posedge clk); #1;
    rd_en = 1'b0; wr_en = 1'b0;
    rd(A_ACC1, d);
    check("R13 written acc1 wins", d, 32'h0000_ABCD);
    rd(A_ACC0, d);
    check("R13 acc0 takes pop", d, 32'h11);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule